// File: doc/BRIEF.md
# Free-Running Counter Array with Simultaneous Capture

This block is a fault-isolation test circuit made of several identical binary counters that all run without pause. No counter has an enable, a load or a clear other than the shared reset. Each counter therefore also has a known fan-in structure. Its lowest bit depends only on itself. Its highest bit depends on every bit below it. Bit k toggles once every 2^k cycles.

A period timer fires once every `SNAP_PERIOD` cycles. In that cycle it copies every counter, all in the same clock edge, into a bank of capture registers. The captured bank is then scanned out one entry per cycle over a single narrow port. Each entry carries its counter index and a capture sequence tag. The counters keep stepping while the scan runs.

All counters leave reset at zero together. An external checker can therefore work out the correct value of every entry from the tag alone. A bit that has been flipped in any counter stays wrong in every later capture, so it is seen even if the upset happened long before the scan.

Top module: `ctr_snap_array`

## Requirements
- R1: Each counter adds one on every clock edge after reset, with no enable, including edges where a capture or a scan beat takes place. Captures of the same reset epoch that follow one another therefore differ by exactly `SNAP_PERIOD` modulo 2^`CTR_W`.
- R2: A reset, which is asynchronous and active low, sets every counter to zero at the same time. After release, the first clock edge leaves every counter at one.
- R3: All counters are captured on the same edge. Every entry of one scan carries the same value, and the captured bank does not change between captures.
- R4: A capture takes place on every edge whose number since reset release is a multiple of `SNAP_PERIOD`, counting the first edge as 1. The value captured at edge n is n-1, modulo 2^`CTR_W`.
- R5: The counter width is set by `CTR_W`, with a default of 24. Values wrap from 2^`CTR_W`-1 to 0.
- R6: From the capture edge onward, `rd_valid` is high for exactly `NUM_CTR` consecutive cycles. During that scan `rd_index` runs 0, 1, ..., `NUM_CTR`-1. `rd_valid` is then low until the next capture edge. `SNAP_PERIOD` must exceed `NUM_CTR`.
- R7: `rd_tag` is 0 after reset and increases by one on each capture edge, so the first capture has tag 1. It wraps modulo 2^`TAG_W`. The entry scanned with tag t holds t*`SNAP_PERIOD`-1 while t has not wrapped.
- R8: While reset is held, `rd_valid`, `rd_index`, `rd_data` and `rd_tag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every counter steps on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | output | 1 | High while a scan beat is being presented |
| rd_index | output | $clog2(NUM_CTR) | Counter index of the current beat |
| rd_data | output | CTR_W | Captured value of that counter |
| rd_tag | output | TAG_W | Sequence number of the capture being scanned |

## Verification
Two things happen on every capture edge: the counters step, and the capture bank loads. The bench judges the outcome by demanding the exact value n-1 for a capture at edge n, so a capture one edge early or late, or of the stepped value, is caught. The period is chosen so that some captures fall right at the counter wrap. Resets are also dropped in at random points, including in the middle of a scan, so that capture timing restarts from varied phases.

// File: rtl/ctr_snap_pkg.sv
package ctr_snap_pkg;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

endpackage

// File: rtl/ctr_bank.sv
module ctr_bank #(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CTR_W-1:0] cnt_o [NUM_CTR]
);

    logic [CTR_W-1:0] cnt_d [NUM_CTR];
    logic [CTR_W-1:0] cnt_q [NUM_CTR];

    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            cnt_d[i] = cnt_q[i] + CTR_W'(1);
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_ctr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q[g] <= '0;
                else        cnt_q[g] <= cnt_d[g];
            end
            if (g > 0) begin : g_peer
                // R2: counters leave reset together and stay in lockstep
                assert_lockstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    cnt_q[g] == cnt_q[0]);
            end
        end
    endgenerate

    // R1: no enable, the counter steps on every edge after reset
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q[0] == CTR_W'($past(cnt_q[0]) + 1'b1));

    assign cnt_o = cnt_q;

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
    import ctr_snap_pkg::*;
#(
    parameter int NUM_CTR     = 8,
    parameter int SNAP_PERIOD = 64,
    parameter int TAG_W       = 8,
    localparam int IDX_W      = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
    localparam int PER_W      = (SNAP_PERIOD > 1) ? $clog2(SNAP_PERIOD) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             snap_o,
    output logic             rd_valid_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic [TAG_W-1:0] rd_tag_o
);

    typedef struct packed {
        logic [PER_W-1:0] period;
        scan_state_e      state;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  snap;

    always_comb begin
        ctl_d = ctl_q;
        snap  = (ctl_q.period == PER_W'(SNAP_PERIOD - 1));
        if (snap) begin
            ctl_d.period = '0;
            ctl_d.tag    = ctl_q.tag + TAG_W'(1);
            ctl_d.state  = SCAN_RUN;
            ctl_d.idx    = '0;
        end else begin
            ctl_d.period = ctl_q.period + PER_W'(1);
            if (ctl_q.state == SCAN_RUN) begin
                if (ctl_q.idx == IDX_W'(NUM_CTR - 1)) begin
                    ctl_d.state = SCAN_IDLE;
                    ctl_d.idx   = '0;
                end else begin
                    ctl_d.idx = ctl_q.idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{period: '0, state: SCAN_IDLE, idx: '0, tag: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign snap_o     = snap;
    assign rd_valid_o = (ctl_q.state == SCAN_RUN);
    assign rd_idx_o   = ctl_q.idx;
    assign rd_tag_o   = ctl_q.tag;

    // R6: each beat advances the index by one
    assert_scan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && rd_idx_o != IDX_W'(NUM_CTR - 1)) |=>
            (rd_valid_o && rd_idx_o == IDX_W'($past(rd_idx_o) + 1'b1)));
    // R6: the scan closes after its last index unless a new capture starts
    assert_scan_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && rd_idx_o == IDX_W'(NUM_CTR - 1) && !snap) |=> !rd_valid_o);
    // R7: the tag advances on the capture edge
    assert_tag_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> rd_tag_o == TAG_W'($past(rd_tag_o) + 1'b1));

    initial begin
        assert_period_fits_R6: assert (SNAP_PERIOD > NUM_CTR);
    end

endmodule

// File: rtl/snap_store.sv
module snap_store #(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 24,
    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_i,
    input  logic [CTR_W-1:0] cnt_i [NUM_CTR],
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [CTR_W-1:0] rd_data_o
);

    logic [CTR_W-1:0] img_d [NUM_CTR];
    logic [CTR_W-1:0] img_q [NUM_CTR];

    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            img_d[i] = snap_i ? cnt_i[i] : img_q[i];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CTR; g++) begin : g_img
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) img_q[g] <= '0;
                else        img_q[g] <= img_d[g];
            end
            // R3: the captured bank holds between captures
            assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !snap_i |=> $stable(img_q[g]));
        end
    endgenerate

    assign rd_data_o = img_q[rd_idx_i];

endmodule

// File: rtl/ctr_snap_array.sv
module ctr_snap_array #(
    parameter int NUM_CTR     = 8,
    parameter int CTR_W       = 24,
    parameter int SNAP_PERIOD = 64,
    parameter int TAG_W       = 8,
    localparam int IDX_W      = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_index,
    output logic [CTR_W-1:0] rd_data,
    output logic [TAG_W-1:0] rd_tag
);

    logic [CTR_W-1:0] cnt [NUM_CTR];
    logic             snap;

    ctr_bank #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    snap_ctrl #(.NUM_CTR(NUM_CTR), .SNAP_PERIOD(SNAP_PERIOD), .TAG_W(TAG_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap_o     (snap),
        .rd_valid_o (rd_valid),
        .rd_idx_o   (rd_index),
        .rd_tag_o   (rd_tag)
    );

    snap_store #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_i    (snap),
        .cnt_i     (cnt),
        .rd_idx_i  (rd_index),
        .rd_data_o (rd_data)
    );

    // R4: the first beat after a capture shows the value the counters held on that edge
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (rd_valid && rd_index == '0 && rd_data == $past(cnt[0])));

endmodule

// File: tb/ctr_snap_array_test.sv
`timescale 1ns/1ps
module ctr_snap_array_test;

    localparam int N   = 8;
    localparam int W   = 10;
    localparam int P   = 32;
    localparam int TW  = 4;
    localparam int IW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_valid;
    logic [IW-1:0] rd_index;
    logic [W-1:0]  rd_data;
    logic [TW-1:0] rd_tag;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    bit done   = 1'b0;
    int first_val;
    int prev_burst;

    always #2.5 clk = ~clk;

    ctr_snap_array #(.NUM_CTR(N), .CTR_W(W), .SNAP_PERIOD(P), .TAG_W(TW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_index (rd_index),
        .rd_data  (rd_data),
        .rd_tag   (rd_tag)
    );

    function automatic int exp_value(int n);
        return ((n / P) * P - 1) % (1 << W);
    endfunction

    function automatic int exp_tag(int n);
        return (n / P) % (1 << TW);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, edges);
        end
    endtask

    // reference edge count since reset release
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R8 valid", int'(rd_valid), 0);
                check("R8 index", int'(rd_index), 0);
                check("R8 data", int'(rd_data), 0);
                check("R8 tag", int'(rd_tag), 0);
                prev_burst = -1;
            end else begin
                automatic int ph = edges % P;
                automatic bit vexp = (edges >= P) && (ph < N);
                check("R6 valid", int'(rd_valid), int'(vexp));
                check("R7 tag", int'(rd_tag), exp_tag(edges));
                if (vexp) begin
                    check("R6 index", int'(rd_index), ph);
                    check("R4 R5 data", int'(rd_data), exp_value(edges));
                    if (ph == 0) begin
                        first_val = int'(rd_data);
                        if (prev_burst >= 0)
                            check("R1 step", (first_val - prev_burst + (1 << W)) % (1 << W), P % (1 << W));
                        prev_burst = first_val;
                    end else begin
                        check("R3 same", int'(rd_data), first_val);
                    end
                end
            end
        end
    end

    task automatic pulse_reset(int len);
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (len) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd2718));
        prev_burst = -1;
        first_val  = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2: first edge must give 1; R5: long run crosses the wrap at 1024
        repeat (2500) @(posedge clk);
        // directed: reset in the middle of a scan
        wait (rd_valid && rd_index == IW'(3));
        pulse_reset(2);
        repeat (200) @(posedge clk);
        // random reset points and lengths
        for (int k = 0; k < 12; k++) begin
            repeat (40 + ($urandom % 400)) @(posedge clk);
            pulse_reset(1 + ($urandom % 5));
        end
        repeat (1200) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        done = 1'b1;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule